// File: doc/BRIEF.md
# SD host status and interrupt registers

This block is the register file that sits between a 32-bit word-addressed bus and the engines of an SD card host controller. Software programs the command, argument, data and clock settings through it. It reads back response words that the command engine presents. The engines themselves are outside the block; their completion and error events arrive on input pins.

Each event is caught in a sticky status bit. Software acknowledges events by writing ones to a separate clear register. A mask selects which sticky bits drive a single level interrupt line. The card-detect and write-protect pins are synchronized and read live next to the sticky bits. Any change of the synchronized card-detect level raises a card-change event. A self-clearing reset bit in the command register flushes the status and mask for a fixed number of cycles.

Top module: `sdh_regs`

## Requirements
- R1: After rst_ni is released, irq_o and ctrl_rst_o are 0 and every writable register reads 0. With card_det_i and wr_prot_i low, status (offset 40) reads 0.
- R2: These storage registers read back what was written and drive their outputs: argument (offset 4, 32 bits), data timer (32, 32 bits), data control (28, bits 7:0), clock control (56, bits 9:0) and command (0, bits 9:0). Writable bits above each field read 0. An access with addr_i[1:0] not 0 hits no register and reads 0.
- R3: The block has the following read-only locations. Offsets 8, 12, 16 and 20 return rsp_i[31:0], [63:32], [95:64] and [127:96]. Offset 24 returns rsp_cmd_i. Offset 68 returns FIFO_WORDS and offset 72 returns REVISION. Writes to these locations change nothing.
- R4: A one-cycle pulse on evt_i[k] sets status bit k. The bit stays set until it is cleared. The bit meanings are: 0 response CRC fail, 1 data CRC fail, 2 response timeout, 3 data timeout, 4 response CRC ok, 5 data CRC ok, 6 command sent, 7 data end, 8 FIFO underrun and 9 FIFO overrun.
- R5: Writing the clear register (offset 44) clears each status bit 0 to 10 whose written bit is 1. Bits written as 0 are left unchanged. The clear register reads 0.
- R6: An event on a bit in the same cycle as a clear of that bit leaves the bit set.
- R7: Status bit 11 is the synchronized card_det_i level and status bit 12 is the synchronized wr_prot_i level. Neither bit is sticky, and a clear write does not affect them.
- R8: Every change of the synchronized card-detect level sets sticky status bit 10 (card change).
- R9: The interrupt mask (offset 48, bits 10:0) reads back as written. irq_o is a registered level equal to the OR of status and mask over bits 0 to 10. irq_o stays 0 while the mask is 0.
- R10: Writing command bit 10 as 1 starts a soft reset. ctrl_rst_o and command bit 10 read 1 for exactly RST_CYCLES (8) cycles and then clear. While the reset runs, the sticky bits and the mask are held at 0, so events in that window are discarded. Other registers keep their values.
- R11: Power control (offset 52) keeps bits 4:0. pwr_on_o is bit 4 and vdd_code_o is bits 3:0.
- R12: Bus width (offset 60) stores bit 0 (1-bit mode, bus1_o) and bit 2 (4-bit mode, bus4_o). Bit 3 always reads BUS4_OK and ignores writes.
- R13: Data length (offset 36) keeps only bits 23:0. It drives dlen_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the current address |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| evt_i | input | 10 | Event pulses for status bits 0 to 9 |
| card_det_i | input | 1 | Card-detect level, asynchronous |
| wr_prot_i | input | 1 | Write-protect level, asynchronous |
| rsp_i | input | 4*DATA_W | Response words from the command engine |
| rsp_cmd_i | input | 7 | Responded command index and application flag |
| irq_o | output | 1 | Level interrupt |
| ctrl_rst_o | output | 1 | Soft reset in progress |
| cmd_o | output | 10 | Command register bits 9:0 |
| arg_o | output | DATA_W | Command argument |
| dctrl_o | output | 8 | Data control field |
| dtimer_o | output | DATA_W | Data timer |
| dlen_o | output | 24 | Data length |
| clk_ctl_o | output | 10 | Clock control field |
| pwr_on_o | output | 1 | Card power enable |
| vdd_code_o | output | 4 | Voltage code |
| bus1_o | output | 1 | 1-bit bus mode |
| bus4_o | output | 1 | 4-bit bus mode |

## Verification
The hardest case to reach is a collision between an event and a clear. The bench has to raise an event pin and present a clear write to that bit on the same clock edge. It does this by driving both in one half-cycle, and it clears a different set bit in the same write, so that the check also shows the clear acted. A second hard case is an event arriving inside the soft-reset window. The bench counts cycles from the command write and pulses an event partway through the window. It checks ctrl_rst_o on the last busy cycle and on the first idle cycle, and then reads status and mask to confirm they are clear. Card change can only be produced through the synchronizer, so the bench toggles card_det_i and waits out the synchronizer stages before it reads status.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam int unsigned EVT_N = 11;

  // word indices (byte offset / 4)
  localparam int unsigned A_CMD    = 0;
  localparam int unsigned A_ARG    = 1;
  localparam int unsigned A_RSP0   = 2;
  localparam int unsigned A_RSPCMD = 6;
  localparam int unsigned A_DCTRL  = 7;
  localparam int unsigned A_DTIMER = 8;
  localparam int unsigned A_DLEN   = 9;
  localparam int unsigned A_STAT   = 10;
  localparam int unsigned A_CLR    = 11;
  localparam int unsigned A_MASK   = 12;
  localparam int unsigned A_PWR    = 13;
  localparam int unsigned A_CLK    = 14;
  localparam int unsigned A_BUS    = 15;
  localparam int unsigned A_FEAT   = 17;
  localparam int unsigned A_REV    = 18;

  localparam int unsigned RSP_N   = 4;
  localparam int unsigned CMD_W   = 10;
  localparam int unsigned DCTRL_W = 8;
  localparam int unsigned DLEN_W  = 24;
  localparam int unsigned CLK_W   = 10;
  localparam int unsigned PWR_W   = 5;
  localparam int unsigned B_SRST  = 10;
  localparam int unsigned B_BUS1  = 0;
  localparam int unsigned B_BUS4  = 2;

  typedef logic [EVT_N-1:0] evt_vec_t;
endpackage

// File: rtl/sdh_sync.sv
module sdh_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdh_evt_status.sv
module sdh_evt_status #(
  parameter int unsigned N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic [N-1:0] hw_set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_bits_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wdata_i,
  output logic [N-1:0] sticky_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] sticky_q, mask_q, clr_eff;
  logic         irq_q;

  assign clr_eff = clr_we_i ? clr_bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= |(sticky_q & mask_q);
      if (flush_i) begin
        sticky_q <= '0;
        mask_q   <= '0;
      end else begin
        // set dominates clear
        sticky_q <= (sticky_q & ~clr_eff) | hw_set_i;
        if (mask_we_i) mask_q <= mask_wdata_i;
      end
    end
  end

  assign sticky_o = sticky_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/sdh_soft_rst.sv
module sdh_soft_rst #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (start_i) begin
      cnt_q <= CNT_W'(CYCLES);
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sdh_regs.sv
module sdh_regs
  import sdh_pkg::*;
#(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RST_CYCLES = 8,
  parameter int unsigned SYNC_STG   = 2,
  parameter int unsigned FIFO_WORDS = 4,
  parameter logic [31:0] REVISION   = 32'h0001_0200,
  parameter bit          BUS4_OK    = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  input  logic [EVT_N-2:0]        evt_i,
  input  logic                    card_det_i,
  input  logic                    wr_prot_i,
  input  logic [RSP_N*DATA_W-1:0] rsp_i,
  input  logic [6:0]              rsp_cmd_i,
  output logic                    irq_o,
  output logic                    ctrl_rst_o,
  output logic [CMD_W-1:0]        cmd_o,
  output logic [DATA_W-1:0]       arg_o,
  output logic [DCTRL_W-1:0]      dctrl_o,
  output logic [DATA_W-1:0]       dtimer_o,
  output logic [DLEN_W-1:0]       dlen_o,
  output logic [CLK_W-1:0]        clk_ctl_o,
  output logic                    pwr_on_o,
  output logic [PWR_W-2:0]        vdd_code_o,
  output logic                    bus1_o,
  output logic                    bus4_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             hit, we;
  logic [1:0]       lvl_s;
  logic             cd_s, wp_s, cd_d_q, card_chg;
  evt_vec_t         hw_set, sticky, mask;
  logic             busy, srst_start;

  logic [CMD_W-1:0]   cmd_q;
  logic [DATA_W-1:0]  arg_q, dtimer_q;
  logic [DCTRL_W-1:0] dctrl_q;
  logic [DLEN_W-1:0]  dlen_q;
  logic [CLK_W-1:0]   clk_q;
  logic [PWR_W-1:0]   pwr_q;
  logic               bus1_q, bus4_q;

  assign idx = addr_i[ADDR_W-1:2];
  assign hit = (addr_i[1:0] == 2'b00);
  assign we  = wr_en_i & hit;

  sdh_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wr_prot_i, card_det_i}),
    .q_o   (lvl_s)
  );
  assign cd_s = lvl_s[0];
  assign wp_s = lvl_s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cd_d_q <= 1'b0;
    else         cd_d_q <= cd_s;
  end
  assign card_chg = cd_s ^ cd_d_q;
  assign hw_set   = {card_chg, evt_i};

  assign srst_start = we && (idx == IDX_W'(A_CMD)) && wdata_i[B_SRST];

  sdh_soft_rst #(.CYCLES(RST_CYCLES)) u_srst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(srst_start),
    .busy_o (busy)
  );

  sdh_evt_status #(.N(EVT_N)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (busy),
    .hw_set_i    (hw_set),
    .clr_we_i    (we && (idx == IDX_W'(A_CLR))),
    .clr_bits_i  (wdata_i[EVT_N-1:0]),
    .mask_we_i   (we && (idx == IDX_W'(A_MASK))),
    .mask_wdata_i(wdata_i[EVT_N-1:0]),
    .sticky_o    (sticky),
    .mask_o      (mask),
    .irq_o       (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      arg_q    <= '0;
      dctrl_q  <= '0;
      dtimer_q <= '0;
      dlen_q   <= '0;
      clk_q    <= '0;
      pwr_q    <= '0;
      bus1_q   <= 1'b0;
      bus4_q   <= 1'b0;
    end else if (we) begin
      case (idx)
        IDX_W'(A_CMD):    cmd_q    <= wdata_i[CMD_W-1:0];
        IDX_W'(A_ARG):    arg_q    <= wdata_i;
        IDX_W'(A_DCTRL):  dctrl_q  <= wdata_i[DCTRL_W-1:0];
        IDX_W'(A_DTIMER): dtimer_q <= wdata_i;
        IDX_W'(A_DLEN):   dlen_q   <= wdata_i[DLEN_W-1:0];
        IDX_W'(A_CLK):    clk_q    <= wdata_i[CLK_W-1:0];
        IDX_W'(A_PWR):    pwr_q    <= wdata_i[PWR_W-1:0];
        IDX_W'(A_BUS): begin
          bus1_q <= wdata_i[B_BUS1];
          bus4_q <= wdata_i[B_BUS4];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (idx)
        IDX_W'(A_CMD):    rdata_o = DATA_W'({busy, cmd_q});
        IDX_W'(A_ARG):    rdata_o = arg_q;
        IDX_W'(A_RSPCMD): rdata_o = DATA_W'(rsp_cmd_i);
        IDX_W'(A_DCTRL):  rdata_o = DATA_W'(dctrl_q);
        IDX_W'(A_DTIMER): rdata_o = dtimer_q;
        IDX_W'(A_DLEN):   rdata_o = DATA_W'(dlen_q);
        IDX_W'(A_STAT):   rdata_o = DATA_W'({wp_s, cd_s, sticky});
        IDX_W'(A_MASK):   rdata_o = DATA_W'(mask);
        IDX_W'(A_PWR):    rdata_o = DATA_W'(pwr_q);
        IDX_W'(A_CLK):    rdata_o = DATA_W'(clk_q);
        IDX_W'(A_BUS):    rdata_o = DATA_W'({BUS4_OK, bus4_q, 1'b0, bus1_q});
        IDX_W'(A_FEAT):   rdata_o = DATA_W'(FIFO_WORDS);
        IDX_W'(A_REV):    rdata_o = DATA_W'(REVISION);
        default:          rdata_o = '0;
      endcase
      for (int i = 0; i < RSP_N; i++) begin
        if (idx == IDX_W'(A_RSP0 + i)) rdata_o = rsp_i[i*DATA_W +: DATA_W];
      end
    end
  end

  assign ctrl_rst_o = busy;
  assign cmd_o      = cmd_q;
  assign arg_o      = arg_q;
  assign dctrl_o    = dctrl_q;
  assign dtimer_o   = dtimer_q;
  assign dlen_o     = dlen_q;
  assign clk_ctl_o  = clk_q;
  assign pwr_on_o   = pwr_q[PWR_W-1];
  assign vdd_code_o = pwr_q[PWR_W-2:0];
  assign bus1_o     = bus1_q;
  assign bus4_o     = bus4_q;
endmodule

// File: rtl/sdh_regs_chk.sv
module sdh_regs_chk #(
  parameter int unsigned N      = 11,
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              srst_bit_i,
  input logic [N-2:0]      evt_i,
  input logic              ctrl_rst_i,
  input logic [N-1:0]      sticky_i,
  input logic [N-1:0]      mask_i,
  input logic              irq_i
);
  logic clr_wr, cmd_srst_wr;
  assign clr_wr      = wr_en_i && (addr_i == ADDR_W'(sdh_pkg::A_CLR * 4));
  assign cmd_srst_wr = wr_en_i && (addr_i == ADDR_W'(sdh_pkg::A_CMD * 4)) && srst_bit_i;

  p_evt_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rst_i |=> ((sticky_i[N-2:0] & $past(evt_i)) == $past(evt_i)));

  p_sticky_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_rst_i && !clr_wr) |=> ((sticky_i & $past(sticky_i)) == $past(sticky_i)));

  p_irq_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> !irq_i);

  p_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_i |=> (sticky_i == '0 && mask_i == '0));

  p_srst_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_rst_i) |-> $past(cmd_srst_wr));
endmodule

bind sdh_regs sdh_regs_chk #(.N(sdh_pkg::EVT_N), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .srst_bit_i(wdata_i[sdh_pkg::B_SRST]),
  .evt_i     (evt_i),
  .ctrl_rst_i(ctrl_rst_o),
  .sticky_i  (sticky),
  .mask_i    (mask),
  .irq_i     (irq_o)
);

// File: tb/sdh_regs_tb.sv
module sdh_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [6:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [9:0]   evt = '0;
  logic         card_det = 1'b0, wr_prot = 1'b0;
  logic [127:0] rsp = '0;
  logic [6:0]   rsp_cmd = '0;
  logic         irq, ctrl_rst, pwr_on, bus1, bus4;
  logic [9:0]   cmd, clk_ctl;
  logic [31:0]  arg, dtimer;
  logic [7:0]   dctrl;
  logic [23:0]  dlen;
  logic [3:0]   vdd;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .card_det_i(card_det), .wr_prot_i(wr_prot),
    .rsp_i(rsp), .rsp_cmd_i(rsp_cmd), .irq_o(irq), .ctrl_rst_o(ctrl_rst),
    .cmd_o(cmd), .arg_o(arg), .dctrl_o(dctrl), .dtimer_o(dtimer), .dlen_o(dlen),
    .clk_ctl_o(clk_ctl), .pwr_on_o(pwr_on), .vdd_code_o(vdd), .bus1_o(bus1), .bus4_o(bus4)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [9:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 ctrl_rst", {31'b0, ctrl_rst}, 0);
    rd(7'd40, d); chk("R1 status", d, 0);
    rd(7'd0, d);  chk("R1 cmd", d, 0);
    rd(7'd52, d); chk("R1 power", d, 0);
    rd(7'd60, d); chk("R1 R12 bus width", d, 32'h8);
  endtask

  task automatic t_storage();
    logic [31:0] d;
    wr(7'd4, 32'hDEADBEEF);  rd(7'd4, d);  chk("R2 argument", d, 32'hDEADBEEF);
    chk("R2 arg_o", arg, 32'hDEADBEEF);
    wr(7'd32, 32'h1234_5678); rd(7'd32, d); chk("R2 timer", d, 32'h1234_5678);
    wr(7'd28, 32'hFFFF);     rd(7'd28, d); chk("R2 data ctrl", d, 32'hFF);
    wr(7'd56, 32'hFFFF);     rd(7'd56, d); chk("R2 clock", d, 32'h3FF);
    wr(7'd0, 32'h0000_003F); rd(7'd0, d);  chk("R2 command", d, 32'h3F);
    wr(7'd5, 32'h0);         rd(7'd4, d);  chk("R2 misaligned write", d, 32'hDEADBEEF);
    rd(7'd5, d); chk("R2 misaligned read", d, 0);
    wr(7'd36, 32'hFFFF_FFFF); rd(7'd36, d); chk("R13 length", d, 32'h00FF_FFFF);
    chk("R13 dlen_o", {8'b0, dlen}, 32'h00FF_FFFF);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    rsp = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    rsp_cmd = 7'h52;
    for (int i = 0; i < 4; i++) begin
      rd(7'(8 + 4*i), d); chk("R3 response word", d, {8{4'(i + 1)}});
    end
    rd(7'd24, d); chk("R3 response cmd", d, 32'h52);
    wr(7'd68, 32'hFFFF); rd(7'd68, d); chk("R3 feature", d, 32'd4);
    wr(7'd72, 32'h0);    rd(7'd72, d); chk("R3 revision", d, 32'h0001_0200);
  endtask

  task automatic t_events();
    logic [31:0] d;
    logic [31:0] acc = 0;
    for (int k = 0; k < 10; k++) begin
      pulse(10'(1 << k));
      acc |= 32'(1 << k);
      rd(7'd40, d); chk("R4 sticky set", d, acc);
    end
    wr(7'd44, 32'h155); rd(7'd40, d); chk("R5 partial clear", d, 32'h2AA);
    rd(7'd44, d); chk("R5 clear reads 0", d, 0);
    wr(7'd44, 32'h7FF); rd(7'd40, d); chk("R5 full clear", d, 0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(10'h020);
    @(negedge clk);
    evt = 10'h008; wr_en = 1'b1; addr = 7'd44; wdata = 32'h028;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    rd(7'd40, d); chk("R6 event beats clear", d, 32'h008);
    wr(7'd44, 32'h7FF);
  endtask

  task automatic t_levels();
    logic [31:0] d;
    card_det = 1'b1; repeat (4) @(negedge clk);
    rd(7'd40, d); chk("R7 R8 detect and change", d, 32'hC00);
    wr(7'd44, 32'h7FF); rd(7'd40, d); chk("R7 detect not cleared", d, 32'h800);
    wr_prot = 1'b1; repeat (4) @(negedge clk);
    rd(7'd40, d); chk("R7 write protect", d, 32'h1800);
    card_det = 1'b0; wr_prot = 1'b0; repeat (4) @(negedge clk);
    rd(7'd40, d); chk("R8 removal change", d, 32'h400);
    wr(7'd44, 32'h7FF);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulse(10'h002);
    repeat (2) @(negedge clk);
    chk("R9 masked quiet", {31'b0, irq}, 0);
    wr(7'd48, 32'h002); repeat (2) @(negedge clk);
    chk("R9 irq raised", {31'b0, irq}, 1);
    rd(7'd48, d); chk("R9 mask readback", d, 32'h002);
    wr(7'd44, 32'h002); repeat (2) @(negedge clk);
    chk("R9 irq drops", {31'b0, irq}, 0);
  endtask

  task automatic t_power_bus();
    logic [31:0] d;
    wr(7'd52, 32'hFF); rd(7'd52, d); chk("R11 power read", d, 32'h1F);
    chk("R11 outputs", {27'b0, pwr_on, vdd}, 32'h1F);
    wr(7'd52, 32'h05); chk("R11 power off", {27'b0, pwr_on, vdd}, 32'h05);
    wr(7'd60, 32'h4); rd(7'd60, d); chk("R12 4-bit", d, 32'hC);
    chk("R12 outputs", {30'b0, bus4, bus1}, 32'h2);
    wr(7'd60, 32'hFF); rd(7'd60, d); chk("R12 flag read-only", d, 32'hD);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    wr(7'd4, 32'hCAFE_0001);
    wr(7'd48, 32'h7FF);
    pulse(10'h3FF);
    repeat (2) @(negedge clk);
    chk("R9 irq before reset", {31'b0, irq}, 1);
    wr(7'd0, 32'h415);
    rd(7'd0, d); chk("R10 busy bit", d, 32'h415);
    chk("R10 ctrl_rst_o", {31'b0, ctrl_rst}, 1);
    pulse(10'h011);
    repeat (4) @(negedge clk);
    chk("R10 last busy cycle", {31'b0, ctrl_rst}, 1);
    @(negedge clk);
    chk("R10 reset ends", {31'b0, ctrl_rst}, 0);
    rd(7'd0, d);  chk("R10 busy cleared", d, 32'h015);
    rd(7'd40, d); chk("R10 status flushed", d, 0);
    rd(7'd48, d); chk("R10 mask flushed", d, 0);
    rd(7'd4, d);  chk("R10 argument kept", d, 32'hCAFE_0001);
    chk("R10 irq low", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_storage();
    t_readonly();
    t_events();
    t_race();
    t_levels();
    t_irq();
    t_power_bus();
    t_soft_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule